// File: doc/BRIEF.md
# ECC Correction Write-Back Scheduler

This block sits next to the read path of a memory controller. The ECC decoder sends it an error report. The report carries the failing address, the corrected data word, and one flag for each error class. A correctable single-bit error, reported while automatic correction is enabled, becomes a write request to the same address. The request carries the corrected data; the controller's encoder adds fresh check bits further downstream. The request is offered on a valid/ready handshake toward the command queue.

The write-back is best effort. It is queued only if three things hold in the same cycle as the report: the command queue has a free slot, the write-data buffer has a free entry, and the output holds no request still waiting for acceptance. Otherwise the correction is discarded and never retried. The drop is recorded in a saturating counter, a last-dropped-address register and a sticky flag, and the interrupt is raised. Software reads these through a small register port and clears them by writing ones to the status word. To retry a dropped correction, software reads the dropped address and issues a write with no byte lanes enabled. The controller then reads the location again, and a fresh single-bit report produces a new attempt.

Top module: `ecc_wb_sched`

## Requirements
- R1: A report with `err_vld`=1, `err_sbe`=1 and `auto_corr_en`=1, accepted under R3, raises `wb_valid` after the next clock edge, with `wb_addr`/`wb_data` equal to the reported address and corrected data. These hold stable while `wb_ready` is 0, and `wb_valid` falls after the edge where `wb_ready` is 1.
- R2: With `auto_corr_en`=0, a single-bit report produces no write-back and no drop count, but still sets the single-bit flag and the interrupt.
- R3: A write-back is accepted only when `cq_used` < CQ_DEPTH (default 8) and `wbuf_used` < WB_DEPTH. Otherwise it is dropped: the drop counter increments, the drop flag and interrupt set, and the reported address is stored.
- R4: A single-bit report that arrives while an earlier request is still pending (valid, not ready) is dropped as in R3, and the pending request is left unchanged.
- R5: A double-bit report never produces a write-back. It sets the double-bit flag (status bit 2) and the interrupt (status bit 0).
- R6: When one report carries both error classes, both flags set, and the single-bit part is handled for write-back as in R1 to R4.
- R7: The drop counter saturates at its all-ones value (2^CNT_W−1) and does not wrap.
- R8: Each drop overwrites the stored dropped address with the newest one.
- R9: Writing `reg_wmask` to word 144 clears each status bit whose mask bit is 1. Mask bit 3 also zeroes the counter and the dropped address. An event in the same cycle wins over the clear, so a drop during a bit-3 clear leaves count 1. `irq` follows status bit 0.
- R10: Register map. Word 144 holds status: bit0 interrupt, bit1 single-bit flag, bit2 double-bit flag, bit3 drop flag. Word 145 holds the drop count. Word 146 holds the last dropped address. All other words read 0. Read data and `reg_rvalid` appear one cycle after `reg_rd`.
- R11: A new single-bit report for an address that has already been written back starts a new write-back attempt. Repeated addresses are not suppressed.
- R12: After reset, `wb_valid`, `irq`, `reg_rvalid`, every status bit, the counter and the stored address are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_vld | input | 1 | Error report valid |
| err_sbe | input | 1 | Report is a correctable single-bit error |
| err_dbe | input | 1 | Report is an uncorrectable double-bit error |
| err_addr | input | AW | Failing address |
| err_data | input | DW | Corrected data word |
| auto_corr_en | input | 1 | Enable for automatic correction write-back |
| cq_used | input | $clog2(CQ_DEPTH+1) | Occupied command-queue slots |
| wbuf_used | input | $clog2(WB_DEPTH+1) | Occupied write-data buffer entries |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Command queue accepts the request |
| wb_addr | output | AW | Write-back address |
| wb_data | output | DW | Write-back corrected data |
| irq | output | 1 | Sticky ECC interrupt |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe (status clear) |
| reg_addr | input | 8 | Register word address |
| reg_wmask | input | 4 | Write-one-to-clear mask for status bits |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |

## Verification
A wrong free-space decision shows up one cycle after the report, in two places: `wb_valid` is asserted where it should be low (or the reverse), and the drop count read back through the register port is off by one. A corrupted counter or a corrupted stored address can only be seen through a register read, so the checks read words 145 and 146 right after each drop, and again after a clear that races with a new drop. A sticky flag that does not stick, or that clears the wrong bit, shows at `irq` and in the status word on the first read after the event or the clear.

// File: rtl/ecc_wb_pkg.sv
package ecc_wb_pkg;
  localparam logic [7:0] REG_STATUS   = 8'd144;
  localparam logic [7:0] REG_DROP_CNT = 8'd145;
  localparam logic [7:0] REG_DROP_ADR = 8'd146;

  localparam int ST_IRQ  = 0;
  localparam int ST_SBE  = 1;
  localparam int ST_DBE  = 2;
  localparam int ST_DROP = 3;
  localparam int ST_BITS = 4;

  typedef logic [ST_BITS-1:0] stat_vec_t;
endpackage

// File: rtl/ecc_wb_issue.sv
module ecc_wb_issue #(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int CQ_DEPTH = 8,
  parameter int WB_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            err_vld,
  input  logic                            err_sbe,
  input  logic [AW-1:0]                   err_addr,
  input  logic [DW-1:0]                   err_data,
  input  logic                            auto_corr_en,
  input  logic [$clog2(CQ_DEPTH+1)-1:0]   cq_used,
  input  logic [$clog2(WB_DEPTH+1)-1:0]   wbuf_used,
  input  logic                            wb_ready,
  output logic                            wb_valid,
  output logic [AW-1:0]                   wb_addr,
  output logic [DW-1:0]                   wb_data,
  output logic                            drop_pulse
);
  localparam int CQ_W = $clog2(CQ_DEPTH+1);
  localparam int WB_W = $clog2(WB_DEPTH+1);
  localparam logic [CQ_W-1:0] CQ_LIM = CQ_W'(CQ_DEPTH);
  localparam logic [WB_W-1:0] WB_LIM = WB_W'(WB_DEPTH);

  logic          space, want, take;
  logic          vld_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;

  always_comb begin
    space      = (cq_used < CQ_LIM) && (wbuf_used < WB_LIM) && (!wb_valid || wb_ready);
    want       = err_vld && err_sbe && auto_corr_en;
    take       = want && space;
    drop_pulse = want && !space;
    vld_d      = take || (wb_valid && !wb_ready);
    addr_d     = take ? err_addr : wb_addr;
    data_d     = take ? err_data : wb_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= vld_d;
      if (take) begin
        wb_addr <= addr_d;
        wb_data <= data_d;
      end
    end
  end
endmodule

// File: rtl/ecc_wb_status.sv
module ecc_wb_status
  import ecc_wb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_evt,
  input  logic             dbe_evt,
  input  logic             drop_evt,
  input  logic [AW-1:0]    drop_addr_in,
  input  logic             clr_hit,
  input  stat_vec_t        clr_mask,
  output stat_vec_t        flags,
  output logic [CNT_W-1:0] drop_cnt,
  output logic [AW-1:0]    drop_addr
);
  stat_vec_t        set_vec, clr_vec, flags_d;
  logic [CNT_W-1:0] cnt_base, cnt_d;
  logic [AW-1:0]    addr_d;
  logic             clr_drop;

  always_comb begin
    set_vec          = '0;
    set_vec[ST_IRQ]  = sbe_evt || dbe_evt || drop_evt;
    set_vec[ST_SBE]  = sbe_evt;
    set_vec[ST_DBE]  = dbe_evt;
    set_vec[ST_DROP] = drop_evt;
    clr_vec          = clr_hit ? clr_mask : '0;
    clr_drop         = clr_vec[ST_DROP];
  end

  for (genvar i = 0; i < ST_BITS; i++) begin : g_flag
    always_comb flags_d[i] = (flags[i] && !clr_vec[i]) || set_vec[i];
  end

  always_comb begin
    cnt_base = clr_drop ? '0 : drop_cnt;
    cnt_d    = (drop_evt && (cnt_base != {CNT_W{1'b1}})) ? cnt_base + 1'b1 : cnt_base;
    addr_d   = drop_evt ? drop_addr_in : (clr_drop ? '0 : drop_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      drop_cnt  <= '0;
      drop_addr <= '0;
    end else begin
      flags     <= flags_d;
      drop_cnt  <= cnt_d;
      drop_addr <= addr_d;
    end
  end
endmodule

// File: rtl/ecc_wb_regs.sv
module ecc_wb_regs
  import ecc_wb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  stat_vec_t        flags,
  input  logic [CNT_W-1:0] drop_cnt,
  input  logic [AW-1:0]    drop_addr,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid
);
  logic [31:0] word;

  always_comb begin
    case (reg_addr)
      REG_STATUS:   word = 32'(flags);
      REG_DROP_CNT: word = 32'(drop_cnt);
      REG_DROP_ADR: word = 32'(drop_addr);
      default:      word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= word;
    end
  end
endmodule

// File: rtl/ecc_wb_sched.sv
module ecc_wb_sched
  import ecc_wb_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int CQ_DEPTH = 8,
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           err_vld,
  input  logic                           err_sbe,
  input  logic                           err_dbe,
  input  logic [AW-1:0]                  err_addr,
  input  logic [DW-1:0]                  err_data,
  input  logic                           auto_corr_en,
  input  logic [$clog2(CQ_DEPTH+1)-1:0]  cq_used,
  input  logic [$clog2(WB_DEPTH+1)-1:0]  wbuf_used,
  output logic                           wb_valid,
  input  logic                           wb_ready,
  output logic [AW-1:0]                  wb_addr,
  output logic [DW-1:0]                  wb_data,
  output logic                           irq,
  input  logic                           reg_rd,
  input  logic                           reg_wr,
  input  logic [7:0]                     reg_addr,
  input  logic [3:0]                     reg_wmask,
  output logic [31:0]                    reg_rdata,
  output logic                           reg_rvalid
);
  logic             drop_pulse;
  logic             clr_hit;
  stat_vec_t        flags;
  logic [CNT_W-1:0] drop_cnt;
  logic [AW-1:0]    drop_addr;

  assign clr_hit = reg_wr && (reg_addr == REG_STATUS);
  assign irq     = flags[ST_IRQ];

  ecc_wb_issue #(.AW(AW), .DW(DW), .CQ_DEPTH(CQ_DEPTH), .WB_DEPTH(WB_DEPTH)) u_issue (
    .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_sbe(err_sbe),
    .err_addr(err_addr), .err_data(err_data), .auto_corr_en(auto_corr_en),
    .cq_used(cq_used), .wbuf_used(wbuf_used), .wb_ready(wb_ready),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .drop_pulse(drop_pulse)
  );

  ecc_wb_status #(.AW(AW), .CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .sbe_evt(err_vld && err_sbe), .dbe_evt(err_vld && err_dbe),
    .drop_evt(drop_pulse), .drop_addr_in(err_addr),
    .clr_hit(clr_hit), .clr_mask(reg_wmask),
    .flags(flags), .drop_cnt(drop_cnt), .drop_addr(drop_addr)
  );

  ecc_wb_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .flags(flags), .drop_cnt(drop_cnt), .drop_addr(drop_addr),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );
endmodule

// File: rtl/ecc_wb_sched_chk.sv
module ecc_wb_sched_chk #(
  parameter int AW       = 32,
  parameter int CQ_DEPTH = 8,
  parameter int CNT_W    = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          err_vld,
  input logic                          err_sbe,
  input logic                          err_dbe,
  input logic                          auto_corr_en,
  input logic [$clog2(CQ_DEPTH+1)-1:0] cq_used,
  input logic                          wb_valid,
  input logic                          wb_ready,
  input logic [AW-1:0]                 wb_addr,
  input logic                          irq,
  input logic                          reg_wr,
  input logic [7:0]                    reg_addr,
  input logic [3:0]                    reg_wmask,
  input logic [CNT_W-1:0]              drop_cnt
);
  localparam int CQ_W = $clog2(CQ_DEPTH+1);
  localparam logic [CQ_W-1:0] CQ_LIM = CQ_W'(CQ_DEPTH);

  logic out_free, clr_irq, clr_drop;
  assign out_free = !wb_valid || wb_ready;
  assign clr_irq  = reg_wr && (reg_addr == 8'd144) && reg_wmask[0];
  assign clr_drop = reg_wr && (reg_addr == 8'd144) && reg_wmask[3];

  assert_wb_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  assert_off_no_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld && !auto_corr_en && out_free |=> !wb_valid);

  assert_cq_full_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld && err_sbe && (cq_used >= CQ_LIM) && out_free |=> !wb_valid);

  assert_dbe_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld && !err_sbe && out_free |=> !wb_valid);

  assert_cnt_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == {CNT_W{1'b1}}) && !clr_drop |=> (drop_cnt == {CNT_W{1'b1}}));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq);

  assert_irq_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld && (err_sbe || err_dbe) |=> irq);
endmodule

bind ecc_wb_sched ecc_wb_sched_chk #(.AW(AW), .CQ_DEPTH(CQ_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_sbe(err_sbe), .err_dbe(err_dbe),
  .auto_corr_en(auto_corr_en), .cq_used(cq_used), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_addr(wb_addr), .irq(irq), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wmask(reg_wmask), .drop_cnt(drop_cnt)
);

// File: tb/sim_ecc_wb_sched.sv
`timescale 1ns/1ps
module sim_ecc_wb_sched;
  localparam int AW = 32, DW = 64, CQ = 8, WB = 4, CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          err_vld, err_sbe, err_dbe, auto_corr_en, wb_ready;
  logic [AW-1:0] err_addr;
  logic [DW-1:0] err_data;
  logic [3:0]    cq_used;
  logic [2:0]    wbuf_used;
  logic          wb_valid, irq, reg_rd, reg_wr, reg_rvalid;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic [7:0]    reg_addr;
  logic [3:0]    reg_wmask;
  logic [31:0]   reg_rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  ecc_wb_sched #(.AW(AW), .DW(DW), .CQ_DEPTH(CQ), .WB_DEPTH(WB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_sbe(err_sbe), .err_dbe(err_dbe),
    .err_addr(err_addr), .err_data(err_data), .auto_corr_en(auto_corr_en),
    .cq_used(cq_used), .wbuf_used(wbuf_used), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .irq(irq), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end earlier", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report(input logic s, input logic d, input logic [AW-1:0] a, input logic [DW-1:0] dt);
    @(negedge clk);
    err_vld = 1'b1; err_sbe = s; err_dbe = d; err_addr = a; err_data = dt;
    @(negedge clk);
    err_vld = 1'b0; err_sbe = 1'b0; err_dbe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'd144; reg_wmask = m;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 wb_valid", wb_valid, 0);
    chk("R12 irq", irq, 0);
    rd(8'd144, v); chk("R12 status", v, 0);
    chk("R10 rvalid", reg_rvalid, 1);
    rd(8'd145, v); chk("R12 count", v, 0);
    rd(8'd146, v); chk("R12 addr", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    cq_used = 4'd7; wbuf_used = 3'd3;
    report(1, 0, 32'h0000_1A40, 64'hDEAD_BEEF_0123_4567);
    chk("R1 valid", wb_valid, 1);
    chk("R1 addr", wb_addr, 32'h0000_1A40);
    chk("R1 data", wb_data, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    chk("R1 hold", wb_valid, 1);
    chk("R1 hold addr", wb_addr, 32'h0000_1A40);
    drain();
    chk("R1 release", wb_valid, 0);
    rd(8'd144, v); chk("R10 status sbe", v, 32'h3);
    chk("R9 irq port", irq, 1);
    rd(8'd145, v); chk("R3 no drop", v, 0);
    rd(8'd10, v); chk("R10 unmapped", v, 0);
    clr(4'hF);
    rd(8'd144, v); chk("R9 clear all", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    auto_corr_en = 1'b0;
    report(1, 0, 32'h0000_2000, 64'h1);
    chk("R2 no wb", wb_valid, 0);
    rd(8'd145, v); chk("R2 no drop", v, 0);
    rd(8'd144, v); chk("R2 flags", v, 32'h3);
    auto_corr_en = 1'b1;
    clr(4'hF);
  endtask

  task automatic t_full();
    logic [31:0] v;
    cq_used = 4'd8; wbuf_used = 3'd0;
    report(1, 0, 32'h0000_3300, 64'h2);
    chk("R3 cq full no wb", wb_valid, 0);
    rd(8'd145, v); chk("R3 count cq", v, 1);
    rd(8'd146, v); chk("R3 addr cq", v, 32'h0000_3300);
    rd(8'd144, v); chk("R3 status drop", v, 32'hB);
    chk("R3 irq", irq, 1);
    cq_used = 4'd0; wbuf_used = 3'd4;
    report(1, 0, 32'h0000_4400, 64'h3);
    chk("R3 wbuf full no wb", wb_valid, 0);
    rd(8'd145, v); chk("R3 count wbuf", v, 2);
    rd(8'd146, v); chk("R8 addr overwrite", v, 32'h0000_4400);
    wbuf_used = 3'd0;
  endtask

  task automatic t_busy();
    logic [31:0] v;
    report(1, 0, 32'h0000_5500, 64'h55);
    chk("R4 first taken", wb_valid, 1);
    report(1, 0, 32'h0000_6600, 64'h66);
    chk("R4 pending kept", wb_addr, 32'h0000_5500);
    chk("R4 pending data", wb_data, 64'h55);
    rd(8'd145, v); chk("R4 count", v, 3);
    rd(8'd146, v); chk("R4 drop addr", v, 32'h0000_6600);
    drain();
    chk("R4 drained", wb_valid, 0);
  endtask

  task automatic t_dbe();
    logic [31:0] v;
    clr(4'hF);
    report(0, 1, 32'h0000_7700, 64'h77);
    chk("R5 no wb", wb_valid, 0);
    rd(8'd144, v); chk("R5 status", v, 32'h5);
    rd(8'd145, v); chk("R9 count cleared", v, 0);
    rd(8'd146, v); chk("R9 addr cleared", v, 0);
    clr(4'hF);
    report(1, 1, 32'h0000_8800, 64'h88);
    chk("R6 wb", wb_valid, 1);
    chk("R6 wb addr", wb_addr, 32'h0000_8800);
    rd(8'd144, v); chk("R6 status", v, 32'h7);
    drain();
  endtask

  task automatic t_retry();
    report(1, 0, 32'h0000_9900, 64'h99);
    chk("R11 first", wb_valid, 1);
    drain();
    report(1, 0, 32'h0000_9900, 64'h9A);
    chk("R11 again", wb_valid, 1);
    chk("R11 new data", wb_data, 64'h9A);
    drain();
  endtask

  task automatic t_clear();
    logic [31:0] v;
    clr(4'hF);
    cq_used = 4'd8;
    report(1, 0, 32'h0000_0A00, 64'h0);
    report(1, 0, 32'h0000_0B00, 64'h0);
    clr(4'h1);
    chk("R9 irq cleared", irq, 0);
    rd(8'd144, v); chk("R9 partial clear", v, 32'hA);
    rd(8'd145, v); chk("R9 count kept", v, 2);
    @(negedge clk);
    err_vld = 1'b1; err_sbe = 1'b1; err_addr = 32'h0000_0C00;
    reg_wr = 1'b1; reg_addr = 8'd144; reg_wmask = 4'h8;
    @(negedge clk);
    err_vld = 1'b0; err_sbe = 1'b0; reg_wr = 1'b0;
    rd(8'd145, v); chk("R9 set wins count", v, 1);
    rd(8'd146, v); chk("R9 set wins addr", v, 32'h0000_0C00);
    rd(8'd144, v); chk("R9 set wins flag", v, 32'hB);
    cq_used = 4'd0;
  endtask

  task automatic t_sat();
    logic [31:0] v;
    clr(4'hF);
    cq_used = 4'd8;
    for (int i = 0; i < 17; i++) report(1, 0, 32'h100 + i, 64'h0);
    rd(8'd145, v); chk("R7 saturate", v, 15);
    rd(8'd146, v); chk("R8 last addr", v, 32'h110);
    cq_used = 4'd0;
  endtask

  initial begin
    rst_n = 1'b0; err_vld = 0; err_sbe = 0; err_dbe = 0; err_addr = '0; err_data = '0;
    auto_corr_en = 1'b1; cq_used = '0; wbuf_used = '0; wb_ready = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_disabled();
    t_full();
    t_busy();
    t_dbe();
    t_retry();
    t_clear();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule